// File: doc/BRIEF.md
# USB device state and address register

This block holds the global device state and the function address of a USB device controller. Firmware reaches them through a plain write/read register bus with two words. The state word carries four flags: address state, configured state, remote-wakeup enable and resume status. The address word carries the 8-bit function address and a function-enable bit. The block drives the same state to the rest of the controller on dedicated output pins.

Several fields do not behave like plain storage. Address state can be set by software but is cleared only by a reset. Resume status is set by the bus logic, and software cannot write it. A USB bus reset clears the address, the address state and the configured state. An asynchronous wakeup pin is synchronized inside the block, and a rising edge on it produces a one-cycle resume request, but only while remote wakeup is enabled.

Top module: `usb_dev_state_regs`

## Requirements
- R1: After `rstN` is released, both register words read 0, and `addrState`, `configured`, `funcAddr`, `funcEnable` and `resumeReq` are all 0.
- R2: Writing the state word (`regSel`=0) with bit 0 set puts the device in address state. A write with bit 0 clear leaves address state unchanged.
- R3: Bit 1 of a state-word write sets or clears the configured state. Bit 1 of the state word reads back its current value.
- R4: Bit 2 of a state-word write sets or clears the remote-wakeup enable. Bit 2 of the state word reads back its current value.
- R5: Bit 3 of the state word is the resume status. A `resumeDone` pulse sets it, writes do not change it, a bus reset does not change it, and only `rstN` clears it.
- R6: Writing the address word (`regSel`=1) loads bits 7:0 into the function address and bit 8 into the function-enable bit. Both read back at those positions, and every higher bit reads 0.
- R7: A `busReset` cycle clears address state, configured state and function address. It leaves wakeup enable, function enable and resume status unchanged. A register write in the same cycle as `busReset` is dropped.
- R8: While wakeup is enabled, a rising edge on `wakeAsync` produces exactly one `resumeReq` pulse. The pulse appears at the third rising clock edge after the input rises. A level held high produces no further pulse, and no pulse appears while wakeup is disabled.
- R9: Bits 15:4 of the state word read 0. The read data follows `regSel` combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset, clears all state |
| busReset | input | 1 | USB bus reset seen on the line, one cycle per clear |
| wrEn | input | 1 | Register write strobe |
| regSel | input | 1 | 0 selects the state word, 1 selects the address word |
| wrData | input | 16 | Write data |
| rdData | output | 16 | Read data of the selected word |
| wakeAsync | input | 1 | Asynchronous remote-wakeup request pin |
| resumeDone | input | 1 | Pulse from the bus logic when a resume has been sent |
| resumeReq | output | 1 | One-cycle request to signal resume to the host |
| addrState | output | 1 | Device is in address state |
| configured | output | 1 | Device is in configured state |
| funcAddr | output | 8 | Function address |
| funcEnable | output | 1 | Function endpoints may move data |

## Verification
A corrupted flag shows up on the read port and on the matching state pin after the very next clock edge. The bench therefore reads both words after every write and compares them with a model built from the written values. Address state is the one flag whose mistakes can stay hidden: clearing it by mistake shows only after a write with bit 0 clear or a bus reset, so every write with bit 0 set is followed by one with bit 0 clear. A fault in the wakeup path shows at the `resumeReq` pin: the pulse arrives in the wrong cycle, repeats, or appears with the enable off. The bench counts pulses over a six-cycle window and records the cycle in which each one appears.

// File: rtl/usb_dev_state_pkg.sv
package usb_dev_state_pkg;

  // state word bit positions (firmware decodes these)
  localparam int ST_ADDR_BIT = 0;
  localparam int ST_CFG_BIT  = 1;
  localparam int ST_WAKE_BIT = 2;
  localparam int ST_RES_BIT  = 3;

  // strobes from control to datapath
  typedef struct packed {
    logic wrState;
    logic wrAddr;
    logic wakeRise;
    logic busRst;
  } strobe_t;

endpackage

// File: rtl/usb_dev_state_ctrl.sv
module usb_dev_state_ctrl
  import usb_dev_state_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    wrEn,
  input  logic    regSel,
  input  logic    busReset,
  input  logic    wakeAsync,
  output strobe_t strb
);

  // synchronizer stages plus one delayed copy for edge detection
  logic [SYNC_STAGES:0] syncQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ <= '0;
    else       syncQ <= {syncQ[SYNC_STAGES-1:0], wakeAsync};
  end

  always_comb begin
    strb.busRst   = busReset;
    strb.wrState  = wrEn && !regSel && !busReset;
    strb.wrAddr   = wrEn &&  regSel && !busReset;
    strb.wakeRise = syncQ[SYNC_STAGES-1] && !syncQ[SYNC_STAGES];
  end

  // R8: a detected edge lasts a single cycle
  p_rise_single_r8: assert property (@(posedge clk) disable iff (!rstN)
    strb.wakeRise |=> !strb.wakeRise);

endmodule

// File: rtl/usb_dev_state_dp.sv
module usb_dev_state_dp
  import usb_dev_state_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int FADDR_W = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobe_t            strb,
  input  logic               regSel,
  input  logic [DATA_W-1:0]  wrData,
  input  logic               resumeDone,
  output logic [DATA_W-1:0]  rdData,
  output logic               addrState,
  output logic               configured,
  output logic               wakeEnable,
  output logic               resumeStat,
  output logic [FADDR_W-1:0] funcAddr,
  output logic               funcEnable,
  output logic               resumeReq
);

  localparam int FEN_POS = FADDR_W;

  logic               addrStateQ, configQ, wakeEnQ, resumeStatQ, funcEnQ, resumeReqQ;
  logic [FADDR_W-1:0] funcAddrQ;

  // address state: set by write, cleared only by resets
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                  addrStateQ <= 1'b0;
    else if (strb.busRst)                       addrStateQ <= 1'b0;
    else if (strb.wrState && wrData[ST_ADDR_BIT]) addrStateQ <= 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             configQ <= 1'b0;
    else if (strb.busRst)  configQ <= 1'b0;
    else if (strb.wrState) configQ <= wrData[ST_CFG_BIT];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             wakeEnQ <= 1'b0;
    else if (strb.wrState) wakeEnQ <= wrData[ST_WAKE_BIT];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           resumeStatQ <= 1'b0;
    else if (resumeDone) resumeStatQ <= 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      funcAddrQ <= '0;
      funcEnQ   <= 1'b0;
    end else if (strb.busRst) begin
      funcAddrQ <= '0;
    end else if (strb.wrAddr) begin
      funcAddrQ <= wrData[FADDR_W-1:0];
      funcEnQ   <= wrData[FEN_POS];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) resumeReqQ <= 1'b0;
    else       resumeReqQ <= strb.wakeRise && wakeEnQ;
  end

  always_comb begin
    rdData = '0;
    if (!regSel) begin
      rdData[ST_ADDR_BIT] = addrStateQ;
      rdData[ST_CFG_BIT]  = configQ;
      rdData[ST_WAKE_BIT] = wakeEnQ;
      rdData[ST_RES_BIT]  = resumeStatQ;
    end else begin
      rdData[FADDR_W-1:0] = funcAddrQ;
      rdData[FEN_POS]     = funcEnQ;
    end
  end

  assign addrState  = addrStateQ;
  assign configured = configQ;
  assign wakeEnable = wakeEnQ;
  assign resumeStat = resumeStatQ;
  assign funcAddr   = funcAddrQ;
  assign funcEnable = funcEnQ;
  assign resumeReq  = resumeReqQ;

  // R2: address state never drops without a bus reset
  p_addr_sticky_r2: assert property (@(posedge clk) disable iff (!rstN)
    addrStateQ && !strb.busRst |=> addrStateQ);

  // R3: configured follows the written bit
  p_cfg_write_r3: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrState |=> configQ == $past(wrData[ST_CFG_BIT]));

  // R5: resume status holds until power-on reset
  p_resume_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    resumeStatQ |=> resumeStatQ);

  // R6: address loads from the low byte
  p_addr_load_r6: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrAddr |=> funcAddrQ == $past(wrData[FADDR_W-1:0]));

  // R7: bus reset clears the addressing state
  p_bus_reset_r7: assert property (@(posedge clk) disable iff (!rstN)
    strb.busRst |=> !addrStateQ && !configQ && funcAddrQ == '0);

  // R8: resume request is a single-cycle pulse
  p_req_pulse_r8: assert property (@(posedge clk) disable iff (!rstN)
    resumeReqQ |=> !resumeReqQ);

endmodule

// File: rtl/usb_dev_state_regs.sv
module usb_dev_state_regs
  import usb_dev_state_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int FADDR_W     = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               busReset,
  input  logic               wrEn,
  input  logic               regSel,
  input  logic [DATA_W-1:0]  wrData,
  output logic [DATA_W-1:0]  rdData,
  input  logic               wakeAsync,
  input  logic               resumeDone,
  output logic               resumeReq,
  output logic               addrState,
  output logic               configured,
  output logic [FADDR_W-1:0] funcAddr,
  output logic               funcEnable
);

  strobe_t strb;
  logic    wakeEnable, resumeStat;

  usb_dev_state_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .regSel(regSel),
    .busReset(busReset), .wakeAsync(wakeAsync), .strb(strb)
  );

  usb_dev_state_dp #(.DATA_W(DATA_W), .FADDR_W(FADDR_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .regSel(regSel), .wrData(wrData),
    .resumeDone(resumeDone), .rdData(rdData), .addrState(addrState),
    .configured(configured), .wakeEnable(wakeEnable), .resumeStat(resumeStat),
    .funcAddr(funcAddr), .funcEnable(funcEnable), .resumeReq(resumeReq)
  );

endmodule

// File: tb/test_usb_dev_state_regs.sv
module test_usb_dev_state_regs;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busReset = 1'b0;
  logic        wrEn = 1'b0;
  logic        regSel = 1'b0;
  logic [15:0] wrData = '0;
  logic [15:0] rdData;
  logic        wakeAsync = 1'b0;
  logic        resumeDone = 1'b0;
  logic        resumeReq;
  logic        addrState, configured, funcEnable;
  logic [7:0]  funcAddr;

  int errors = 0;
  int checks = 0;

  always #10 clk = ~clk;

  usb_dev_state_regs i_usb_dev_state_regs (
    .clk(clk), .rstN(rstN), .busReset(busReset), .wrEn(wrEn), .regSel(regSel),
    .wrData(wrData), .rdData(rdData), .wakeAsync(wakeAsync),
    .resumeDone(resumeDone), .resumeReq(resumeReq), .addrState(addrState),
    .configured(configured), .funcAddr(funcAddr), .funcEnable(funcEnable)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [15:0] d);
    @(negedge clk); wrEn = 1'b1; regSel = sel; wrData = d;
    @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic rd(input logic sel, output int v);
    regSel = sel; #1; v = int'(rdData);
  endtask

  task automatic pulseBusRst();
    @(negedge clk); busReset = 1'b1;
    @(negedge clk); busReset = 1'b0;
  endtask

  task automatic wakeWindow(output int cnt, output int at);
    cnt = 0; at = 0;
    for (int i = 1; i <= 6; i++) begin
      @(negedge clk);
      if (resumeReq) begin cnt++; at = i; end
    end
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int v, cnt, at, expAddr;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd(1'b0, v); check("R1 state word", v, 0);
    rd(1'b1, v); check("R1 address word", v, 0);
    check("R1 pins", {addrState, configured, funcEnable, resumeReq, funcAddr}, 0);

    // R2 R3 R4 R9 sweep of all flag values
    for (int s = 0; s < 16; s++) begin
      pulseBusRst();
      wr(1'b0, 16'(s) | 16'hFFF0);
      rd(1'b0, v);
      check("R9 state word after write", v, s & 7);
      check("R2 addrState pin", addrState, s & 1);
      check("R3 configured pin", configured, (s >> 1) & 1);
      wr(1'b0, 16'(s & 4));
      rd(1'b0, v);
      check("R2 bit0 zero keeps address state", v & 1, s & 1);
      check("R3 configured cleared", (v >> 1) & 1, 0);
      check("R4 wake enable readback", (v >> 2) & 1, (s >> 2) & 1);
    end

    // R6 sweep of address word
    for (int a = 0; a < 512; a++) begin
      wr(1'b1, 16'(a) | 16'hFE00);
      rd(1'b1, v);
      check("R6 address word", v, a);
      check("R6 pins", {funcEnable, funcAddr}, a);
    end

    // R7 bus reset keeps wake enable and function enable
    wr(1'b0, 16'h0007);
    wr(1'b1, 16'h01C3);
    pulseBusRst();
    rd(1'b0, v); check("R7 state after bus reset", v, 4);
    rd(1'b1, v); check("R7 address after bus reset", v, 16'h0100);
    // R7 write colliding with bus reset is dropped
    wr(1'b1, 16'h0055);
    @(negedge clk); busReset = 1'b1; wrEn = 1'b1; regSel = 1'b1; wrData = 16'h01AB;
    @(negedge clk); busReset = 1'b0; wrEn = 1'b0;
    rd(1'b1, v); check("R7 collided address write", v, 0);
    @(negedge clk); busReset = 1'b1; wrEn = 1'b1; regSel = 1'b0; wrData = 16'h0003;
    @(negedge clk); busReset = 1'b0; wrEn = 1'b0;
    rd(1'b0, v); check("R7 collided state write", v, 4);

    // R8 wakeup with enable on (wake enable is 1 here)
    @(negedge clk); wakeAsync = 1'b1;
    wakeWindow(cnt, at);
    check("R8 pulse count", cnt, 1);
    check("R8 pulse cycle", at, 3);
    wakeWindow(cnt, at);
    check("R8 held level no repeat", cnt, 0);
    wakeAsync = 1'b0;
    repeat (4) @(negedge clk);
    wr(1'b0, 16'h0000);
    @(negedge clk); wakeAsync = 1'b1;
    wakeWindow(cnt, at);
    check("R8 disabled no pulse", cnt, 0);
    wakeAsync = 1'b0;
    repeat (4) @(negedge clk);

    // R5 resume status
    @(negedge clk); resumeDone = 1'b1;
    @(negedge clk); resumeDone = 1'b0;
    rd(1'b0, v); check("R5 resume set", (v >> 3) & 1, 1);
    wr(1'b0, 16'h0000);
    rd(1'b0, v); check("R5 write no effect", (v >> 3) & 1, 1);
    pulseBusRst();
    rd(1'b0, v); check("R5 bus reset no effect", (v >> 3) & 1, 1);
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); rstN = 1'b1;
    rd(1'b0, v); check("R5 cleared by reset", v, 0);
    expAddr = 0;
    rd(1'b1, v); check("R1 address after reset", v, expAddr);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule